// File: doc/BRIEF.md
# Serial Transmitter with Holding Register

This block turns parallel words into asynchronous serial frames on a single output line. A word is offered on a valid/ready write port and lands in a one-word holding register. As soon as the shift stage is empty and the block is running, the word is copied into the shift stage. A pulse on `buf_freed_o` marks that copy, and the holding register then reads back as zero. Because of this, software or a DMA engine can queue the next word while the current frame is still going out, and consecutive frames leave the line with no idle gap.

Bit timing comes from an external 16x baud tick. The block keeps its own modulo-16 phase counter on that tick, and a frame may only begin when that counter wraps. A three-bit format select chooses the data field:

- seven data bits plus a parity bit
- eight data bits
- eight data bits plus a parity bit
- eight data bits plus a wake-up bit
- nine data bits

Two further selects set odd or even parity and one or two stop bits. A `frame_end_o` pulse warns the system one cycle before the final stop bit begins.

The write port never applies back-pressure: `wr_ready_o` is always high, and a write into a full holding register replaces the pending word. Format, parity and stop selects are sampled when a word moves into the shift stage. Changing them while a frame is in flight does not disturb that frame.

Top module: `uart_serial_tx`

## Requirements
- R1: After reset, `txd_o` is 1, `hold_data_o` is 0, and `buf_freed_o` and `frame_end_o` are 0. Whenever no frame is being sent, the line stays at 1.
- R2: A frame is a 0 start bit, then the data field least significant bit first, then one stop bit of value 1 when `two_stop_i` is 0, or two stop bits when it is 1. Every bit lasts exactly 16 ticks of `tick16_i`.
- R3: The phase counter starts at 0 at reset and advances on each tick. A frame's start bit begins only at the clock edge of the 16th, 32nd, 48th, ... tick after reset (the wrap of that counter).
- R4: `fmt_i` encodings: 011 gives word bits 6:0 plus parity (8-bit field). 001 gives word bits 7:0 (8-bit field). 111 gives word bits 7:0 plus parity (9-bit field). 101 gives word bits 7:0 plus word bit 8 as wake-up bit (9-bit field). 100 gives word bits 8:0 (9-bit field). The reserved codes 000, 010 and 110 behave as 001. Word bits above the field's data width are never sent.
- R5: The parity bit is the last bit of the field. With `odd_par_i` = 0 it equals the XOR of the data bits. With `odd_par_i` = 1 it is the inverse of that XOR.
- R6: `buf_freed_o` is high for exactly the one cycle in which the holding register is copied into the shift stage. With the shift stage empty and `run_i` = 1, this is the cycle right after the write is accepted.
- R7: `frame_end_o` is high for one cycle, the cycle that ends just before the final stop bit begins on `txd_o`.
- R8: `hold_data_o` shows the pending word and reads 0 from the cycle after its copy into the shift stage.
- R9: `wr_ready_o` is always 1. A write while the holding register is full overwrites the pending word.
- R10: If a word is pending when a frame's last stop bit ends, it is copied at that edge and its start bit follows immediately, so successive start bits are exactly one frame length apart.
- R11: While `run_i` is 0, no word moves out of the holding register, no frame begins, and `txd_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16_i | input | 1 | One-cycle pulse at 16 times the baud rate |
| fmt_i | input | 3 | Data field format select |
| odd_par_i | input | 1 | 1 selects odd parity, 0 even |
| two_stop_i | input | 1 | 1 selects two stop bits |
| run_i | input | 1 | Enables transfers and frame starts |
| wr_valid_i | input | 1 | Write request for the holding register |
| wr_ready_o | output | 1 | Write acceptance, always 1 |
| wr_data_i | input | 9 | Word to transmit |
| hold_data_o | output | 9 | Readback of the holding register |
| txd_o | output | 1 | Serial output line, idle high |
| buf_freed_o | output | 1 | Pulse when the holding register is emptied into the shift stage |
| frame_end_o | output | 1 | Pulse one cycle before the final stop bit begins |

## Verification
The hardest situation to reach is the hand-over at the end of a frame. A second word must already be pending at the exact tick-counter wrap that ends the first frame's last stop bit, so that the copy, the `buf_freed_o` pulse and the next start bit all land on that one edge. The bench writes the second word right after the first is copied, while the first frame is still armed and waiting for a wrap. It then measures the distance between the two start bits against the expected frame length. A running count of ticks since reset lets the bench confirm that every start bit falls on a wrap, and that `frame_end_o` falls exactly one cycle ahead of the last stop bit.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int WORD_W = 9;

  typedef enum logic [2:0] {
    FMT_RSV0 = 3'b000,
    FMT_D8   = 3'b001,
    FMT_RSV2 = 3'b010,
    FMT_D7P  = 3'b011,
    FMT_D9   = 3'b100,
    FMT_D8W  = 3'b101,
    FMT_RSV6 = 3'b110,
    FMT_D8P  = 3'b111
  } fmt_e;

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_ARMED = 2'd1,
    SH_SEND  = 2'd2
  } sh_state_e;

endpackage

// File: rtl/uart_tick_phase.sv
module uart_tick_phase #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic roll_o
);
  localparam int PW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_BIT - 1);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ph_q <= '0;
    else if (tick_i)
      ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
  end

  assign roll_o = tick_i && (ph_q == LAST);

  // R3
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    roll_o |=> (ph_q == '0));

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(ph_q));

endmodule

// File: rtl/uart_hold_reg.sv
module uart_hold_reg #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         take_i,
  output logic [W-1:0] data_o,
  output logic         full_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      full_o <= 1'b0;
    end else if (wr_i) begin
      data_o <= wdata_i;
      full_o <= 1'b1;
    end else if (take_i) begin
      data_o <= '0;
      full_o <= 1'b0;
    end
  end

  // R8
  freed_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !wr_i) |=> (data_o == '0 && !full_o));

  // R9
  overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (full_o && data_o == $past(wdata_i)));

endmodule

// File: rtl/uart_frame_fmt.sv
module uart_frame_fmt
  import uart_tx_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [2:0]        fmt_i,
  input  logic              odd_i,
  output logic [WORD_W-1:0] field_o,
  output logic              nine_o
);
  logic par7, par8;

  assign par7 = (^word_i[6:0]) ^ odd_i;
  assign par8 = (^word_i[7:0]) ^ odd_i;

  always_comb begin
    case (fmt_e'(fmt_i))
      FMT_D7P: begin
        field_o = {1'b1, par7, word_i[6:0]};
        nine_o  = 1'b0;
      end
      FMT_D8P: begin
        field_o = {par8, word_i[7:0]};
        nine_o  = 1'b1;
      end
      FMT_D8W, FMT_D9: begin
        field_o = word_i;
        nine_o  = 1'b1;
      end
      default: begin
        field_o = {1'b1, word_i[7:0]};
        nine_o  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              roll_i,
  input  logic              run_i,
  input  logic              avail_i,
  input  logic [WORD_W-1:0] field_i,
  input  logic              nine_i,
  input  logic              two_stop_i,
  output logic              take_o,
  output logic              txd_o,
  output logic              frame_end_o
);
  localparam int SH_W  = WORD_W + 2;
  localparam int CNT_W = $clog2(WORD_W + 3);

  sh_state_e        state_q;
  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] last_q;
  logic [CNT_W-1:0] last_n;
  logic             fin;

  assign last_n = CNT_W'(WORD_W) + CNT_W'(nine_i) + CNT_W'(two_stop_i);
  assign fin    = (state_q == SH_SEND) && roll_i && (idx_q == last_q);
  assign take_o = run_i && avail_i && ((state_q == SH_IDLE) || fin);
  assign frame_end_o = (state_q == SH_SEND) && roll_i && ((idx_q + 1'b1) == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      sh_q    <= '1;
      idx_q   <= '0;
      last_q  <= '0;
      txd_o   <= 1'b1;
    end else begin
      case (state_q)
        SH_IDLE: begin
          if (take_o) begin
            sh_q    <= {2'b11, field_i};
            last_q  <= last_n;
            state_q <= SH_ARMED;
          end
        end
        SH_ARMED: begin
          if (roll_i && run_i) begin
            state_q <= SH_SEND;
            idx_q   <= '0;
            txd_o   <= 1'b0;
          end
        end
        SH_SEND: begin
          if (roll_i) begin
            if (idx_q == last_q) begin
              if (take_o) begin
                sh_q   <= {2'b11, field_i};
                last_q <= last_n;
                idx_q  <= '0;
                txd_o  <= 1'b0;
              end else begin
                state_q <= SH_IDLE;
                txd_o   <= 1'b1;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
              txd_o <= sh_q[0];
              sh_q  <= {1'b1, sh_q[SH_W-1:1]};
            end
          end
        end
        default: state_q <= SH_IDLE;
      endcase
    end
  end

  // R7
  frame_end_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |=> txd_o);

  // R3
  start_on_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd_o) |-> $past(roll_i));

  // R10
  chain_no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && take_o) |=> !txd_o);

  // R6
  flags_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_o, frame_end_o}));

  // R1
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SH_IDLE) |-> txd_o);

endmodule

// File: rtl/uart_serial_tx.sv
module uart_serial_tx
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16_i,
  input  logic [2:0]        fmt_i,
  input  logic              odd_par_i,
  input  logic              two_stop_i,
  input  logic              run_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] hold_data_o,
  output logic              txd_o,
  output logic              buf_freed_o,
  output logic              frame_end_o
);
  logic              roll;
  logic              hold_full;
  logic              take;
  logic [WORD_W-1:0] field;
  logic              nine;

  assign wr_ready_o  = 1'b1;
  assign buf_freed_o = take;

  uart_tick_phase #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick16_i),
    .roll_o (roll)
  );

  uart_hold_reg #(.W(WORD_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_valid_i),
    .wdata_i (wr_data_i),
    .take_i  (take),
    .data_o  (hold_data_o),
    .full_o  (hold_full)
  );

  uart_frame_fmt u_fmt (
    .word_i  (hold_data_o),
    .fmt_i   (fmt_i),
    .odd_i   (odd_par_i),
    .field_o (field),
    .nine_o  (nine)
  );

  uart_tx_shifter u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .roll_i      (roll),
    .run_i       (run_i),
    .avail_i     (hold_full),
    .field_i     (field),
    .nine_i      (nine),
    .two_stop_i  (two_stop_i),
    .take_o      (take),
    .txd_o       (txd_o),
    .frame_end_o (frame_end_o)
  );

  // R11
  run_low_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !wr_valid_i) |=> $stable(hold_data_o));

endmodule

// File: tb/uart_serial_tx_test.sv
module uart_serial_tx_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [2:0] fmt = 3'b001;
  logic       odd_par = 1'b0;
  logic       two_stop = 1'b0;
  logic       run = 1'b1;
  logic       wr_valid = 1'b0;
  logic [8:0] wr_data = '0;
  logic       wr_ready;
  logic [8:0] hold_data;
  logic       txd;
  logic       buf_freed;
  logic       frame_end;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int ticks = 0;
  int fe_cyc = -1;
  int bf_cnt = 0;

  always #5 clk = ~clk;

  uart_serial_tx uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick16_i    (tick16),
    .fmt_i       (fmt),
    .odd_par_i   (odd_par),
    .two_stop_i  (two_stop),
    .run_i       (run),
    .wr_valid_i  (wr_valid),
    .wr_ready_o  (wr_ready),
    .wr_data_i   (wr_data),
    .hold_data_o (hold_data),
    .txd_o       (txd),
    .buf_freed_o (buf_freed),
    .frame_end_o (frame_end)
  );

  // tick every 4 clocks: one bit = 64 clocks
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      tick16 = (ph == 3);
      ph = (ph + 1) % 4;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      if (frame_end) fe_cyc = cyc;
      if (buf_freed) bf_cnt++;
      if (tick16 && rst_n) ticks++;
      cyc++;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_frame(input logic [8:0] d, input logic [2:0] m,
                                   input logic odd, input logic two,
                                   output logic [11:0] b);
    int len;
    logic [8:0] f;
    b = '1;
    case (m)
      3'b011:         begin f = {1'b0, (^d[6:0]) ^ odd, d[6:0]}; len = 8; end
      3'b111:         begin f = {(^d[7:0]) ^ odd, d[7:0]};       len = 9; end
      3'b101, 3'b100: begin f = d;                               len = 9; end
      default:        begin f = {1'b0, d[7:0]};                  len = 8; end
    endcase
    b[0] = 1'b0;
    for (int i = 0; i < len; i++) b[i+1] = f[i];
    return 1 + len + (two ? 2 : 1);
  endfunction

  task automatic write_word(input logic [8:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // waits for a start bit, samples every bit at its middle, checks R2/R3/R7
  task automatic check_frame(input string req, input logic [8:0] d,
                             output int start_cyc);
    logic [11:0] exp_b;
    logic [11:0] got;
    int nb;
    int w;
    nb = exp_frame(d, fmt, odd_par, two_stop, exp_b);
    got = '1;
    w = 0;
    @(negedge clk);
    while (txd !== 1'b0 && w < 5000) begin
      @(negedge clk);
      w++;
    end
    start_cyc = cyc;
    chk(w < 5000, req, "start bit seen", w, 0);
    chk((ticks % 16) == 0, "R3", "start tick phase", ticks % 16, 0);
    repeat (32) @(negedge clk);
    got[0] = txd;
    for (int i = 1; i < nb; i++) begin
      repeat (64) @(negedge clk);
      got[i] = txd;
    end
    for (int i = 0; i < nb; i++)
      chk(got[i] === exp_b[i], req, $sformatf("frame bit %0d", i),
          int'(got[i]), int'(exp_b[i]));
    chk(fe_cyc == start_cyc + 64 * (nb - 1) - 1, "R7", "frame_end cycle",
        fe_cyc, start_cyc + 64 * (nb - 1) - 1);
  endtask

  task automatic t_reset();
    chk(txd === 1'b1, "R1", "idle line", int'(txd), 1);
    chk(hold_data === 9'd0, "R1", "holding readback", int'(hold_data), 0);
    chk(buf_freed === 1'b0 && frame_end === 1'b0, "R1", "flags low",
        int'({buf_freed, frame_end}), 0);
    chk(wr_ready === 1'b1, "R9", "ready high", int'(wr_ready), 1);
  endtask

  task automatic t_single();
    int s;
    fmt = 3'b001; two_stop = 1'b0; odd_par = 1'b0;
    write_word(9'h1A5);
    chk(buf_freed === 1'b1, "R6", "freed after write", int'(buf_freed), 1);
    @(negedge clk);
    chk(hold_data === 9'd0, "R8", "readback zero", int'(hold_data), 0);
    check_frame("R2", 9'h1A5, s);
    repeat (40) @(negedge clk);
    chk(txd === 1'b1, "R1", "line high after frame", int'(txd), 1);
  endtask

  task automatic t_parity();
    int s;
    fmt = 3'b011; odd_par = 1'b0; two_stop = 1'b0;
    write_word(9'h0D3);
    check_frame("R5", 9'h0D3, s);
    repeat (40) @(negedge clk);
    odd_par = 1'b1;
    write_word(9'h0D3);
    check_frame("R5", 9'h0D3, s);
    repeat (40) @(negedge clk);
    fmt = 3'b111; two_stop = 1'b1;
    write_word(9'h15A);
    check_frame("R4", 9'h15A, s);
    repeat (40) @(negedge clk);
    odd_par = 1'b0; two_stop = 1'b0;
  endtask

  task automatic t_nine();
    int s;
    fmt = 3'b101;
    write_word(9'h13C);
    check_frame("R4", 9'h13C, s);
    repeat (40) @(negedge clk);
    fmt = 3'b100; two_stop = 1'b1;
    write_word(9'h0C3);
    check_frame("R4", 9'h0C3, s);
    repeat (40) @(negedge clk);
    fmt = 3'b010; two_stop = 1'b0;
    write_word(9'h17E);
    check_frame("R4", 9'h17E, s);
    repeat (40) @(negedge clk);
  endtask

  task automatic t_back_to_back();
    int s1, s2, b0;
    logic [11:0] dummy;
    int nb;
    fmt = 3'b001; two_stop = 1'b1;
    nb = exp_frame(9'h081, fmt, odd_par, two_stop, dummy);
    b0 = bf_cnt;
    write_word(9'h081);
    write_word(9'h07E);
    @(negedge clk);
    chk(hold_data === 9'h07E, "R8", "pending word readback", int'(hold_data), 'h07E);
    check_frame("R10", 9'h081, s1);
    check_frame("R10", 9'h07E, s2);
    chk(s2 - s1 == 64 * nb, "R10", "start spacing", s2 - s1, 64 * nb);
    chk(bf_cnt - b0 == 2, "R6", "freed count", bf_cnt - b0, 2);
    repeat (40) @(negedge clk);
    two_stop = 1'b0;
  endtask

  task automatic t_run_and_overwrite();
    int s, b0, highs;
    fmt = 3'b001;
    @(negedge clk);
    run = 1'b0;
    b0 = bf_cnt;
    write_word(9'h033);
    write_word(9'h0C6);
    chk(hold_data === 9'h0C6, "R9", "overwrite", int'(hold_data), 'h0C6);
    highs = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (txd === 1'b1) highs++;
    end
    chk(highs == 200, "R11", "line high while stopped", highs, 200);
    chk(bf_cnt == b0, "R11", "no transfer while stopped", bf_cnt - b0, 0);
    chk(hold_data === 9'h0C6, "R11", "word kept", int'(hold_data), 'h0C6);
    run = 1'b1;
    @(negedge clk);
    chk(hold_data === 9'd0, "R8", "readback after run", int'(hold_data), 0);
    chk(bf_cnt - b0 == 1, "R6", "one transfer on run", bf_cnt - b0, 1);
    check_frame("R9", 9'h0C6, s);
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_parity();
    t_nine();
    t_back_to_back();
    t_run_and_overwrite();
    summary();
    $finish;
  end

endmodule